// File: doc/BRIEF.md
# Remote Path Defect Indication Detector

This block sits on the receive side of a path terminating function. Once per frame, an upstream extractor presents the three-bit remote indication field taken from the path status byte, together with a strobe that marks it as valid. The detector sorts each code into one of three remote defect classes: server, connectivity or payload. It then runs a persistence filter for each class, so that a flag changes state only after a run of consecutive valid frames that all argue for the change.

Three codes fall into the server class: the enhanced server code and the two older plain RDI codes. The connectivity code has no far-end status bit of its own downstream, so it gets its own output flag. Whoever reads that flag may use it or ignore it. Either way, the code never disturbs the server or payload flags. The three flags go straight to the far-end status logic.

Top module: `rdi_defect_detector`

## Requirements
- R1: With the server flag clear, ten consecutive valid frames whose code is 3'b101, 3'b100 or 3'b111, in any mix, set `srv_defect` at the clock edge that samples the tenth frame. After nine such frames the flag is still clear.
- R2: With `srv_defect` set, ten consecutive valid frames whose code is not 3'b101, 3'b100 or 3'b111 clear it at the edge that samples the tenth frame.
- R3: `conn_defect` is set by ten consecutive valid frames of code 3'b110 and cleared by ten consecutive valid frames of any other code, with the timing of R1 and R2.
- R4: `pay_defect` is set by ten consecutive valid frames of code 3'b010 and cleared by ten consecutive valid frames of any other code, with the timing of R1 and R2.
- R5: Codes 3'b000, 3'b001 and 3'b011 never count toward setting any flag. They count toward clearing all three flags.
- R6: Code 3'b110 counts toward the connectivity class only. It never counts toward setting `srv_defect` or `pay_defect`, and it counts toward clearing both.
- R7: A valid frame that argues against a pending change restarts that class's run. Nine setting frames, one other code, then nine more setting frames leave the flag clear.
- R8: A cycle with `frame_vld` low changes no flag and breaks no run. Invalid cycles between matching frames do not restart the count.
- R9: While `rst_n` is low, and on the first cycle after it is released, all three flags are clear and every run count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_vld | input | 1 | High for one cycle per frame, when `path_code` is valid |
| path_code | input | 3 | Remote indication field of the path status byte |
| srv_defect | output | 1 | Remote server defect (AIS or LOP at the far end) |
| conn_defect | output | 1 | Remote connectivity defect |
| pay_defect | output | 1 | Remote payload defect |

## Verification
The assertions assume that `path_code` matters only in cycles where `frame_vld` is high. They also assume that at most one sample per frame arrives, so every strobe cycle is counted as a separate frame. The stimulus drives runs of one code that are long enough to cross the ten-frame threshold, and runs short enough to stop just under it. It scatters idle cycles between strobes and leaves `path_code` toggling when the strobe is low, so that any dependence on codes in idle cycles would show up.

// File: rtl/rdi_pkg.sv
package rdi_pkg;
    localparam int NUM_CLS   = 3;
    localparam int CODE_W    = 3;

    typedef enum int unsigned {
        CLS_SRV  = 0,
        CLS_CONN = 1,
        CLS_PAY  = 2
    } rdi_cls_e;

    localparam logic [CODE_W-1:0] CODE_SRV_ENH  = 3'b101;
    localparam logic [CODE_W-1:0] CODE_SRV_OLD0 = 3'b100;
    localparam logic [CODE_W-1:0] CODE_SRV_OLD1 = 3'b111;
    localparam logic [CODE_W-1:0] CODE_CONN     = 3'b110;
    localparam logic [CODE_W-1:0] CODE_PAY      = 3'b010;

    // One bit per class; at most one bit is set for any code.
    function automatic logic [NUM_CLS-1:0] classify(input logic [CODE_W-1:0] code);
        logic [NUM_CLS-1:0] m;
        m = '0;
        unique case (code)
            CODE_SRV_ENH, CODE_SRV_OLD0, CODE_SRV_OLD1: m[CLS_SRV]  = 1'b1;
            CODE_CONN:                                  m[CLS_CONN] = 1'b1;
            CODE_PAY:                                   m[CLS_PAY]  = 1'b1;
            default:                                    m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/rdi_code_classifier.sv
module rdi_code_classifier
    import rdi_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    input  logic               vld_i,
    output logic [NUM_CLS-1:0] match_o,
    output logic               vld_o
);
    always_comb begin
        match_o = classify(code_i);
        vld_o   = vld_i;
    end
endmodule

// File: rtl/rdi_persist_filter.sv
module rdi_persist_filter #(
    parameter int PERSIST = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic match_i,
    output logic flag_o
);
    localparam int CW = (PERSIST > 1) ? $clog2(PERSIST) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

    typedef struct packed {
        logic          flag;
        logic [CW-1:0] run;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vld_i) begin
            if (match_i != st_q.flag) begin
                if (st_q.run == LAST) begin
                    st_d.flag = ~st_q.flag;
                    st_d.run  = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/rdi_defect_detector.sv
module rdi_defect_detector
    import rdi_pkg::*;
#(
    parameter int PERSIST = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic [2:0] path_code,
    output logic       srv_defect,
    output logic       conn_defect,
    output logic       pay_defect
);
    logic [NUM_CLS-1:0] match;
    logic [NUM_CLS-1:0] flags;
    logic               vld;

    rdi_code_classifier u_cls (
        .code_i  (path_code),
        .vld_i   (frame_vld),
        .match_o (match),
        .vld_o   (vld)
    );

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_filt
        rdi_persist_filter #(.PERSIST(PERSIST)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_i   (vld),
            .match_i (match[g]),
            .flag_o  (flags[g])
        );
    end

    assign srv_defect  = flags[CLS_SRV];
    assign conn_defect = flags[CLS_CONN];
    assign pay_defect  = flags[CLS_PAY];
endmodule

// File: rtl/rdi_defect_checker.sv
module rdi_defect_checker #(
    parameter int PERSIST = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_vld,
    input logic [2:0] path_code,
    input logic       srv_defect,
    input logic       conn_defect,
    input logic       pay_defect
);
    logic [2:0]  hit;
    logic [15:0] run_q  [3];
    logic [15:0] miss_q [3];
    logic        clean;

    always_comb begin
        hit[0] = (path_code == 3'b101) || (path_code == 3'b100) || (path_code == 3'b111);
        hit[1] = (path_code == 3'b110);
        hit[2] = (path_code == 3'b010);
        clean  = (path_code == 3'b000) || (path_code == 3'b001) || (path_code == 3'b011);
    end

    for (genvar k = 0; k < 3; k++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q[k]  <= '0;
                miss_q[k] <= '0;
            end else if (frame_vld) begin
                if (hit[k]) begin
                    run_q[k]  <= (run_q[k] >= 16'(PERSIST)) ? run_q[k] : run_q[k] + 16'd1;
                    miss_q[k] <= '0;
                end else begin
                    miss_q[k] <= (miss_q[k] >= 16'(PERSIST)) ? miss_q[k] : miss_q[k] + 16'd1;
                    run_q[k]  <= '0;
                end
            end
        end
    end

    AST_SRV_SET_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srv_defect) |-> run_q[0] >= 16'(PERSIST)); // R1
    AST_SRV_CLR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srv_defect) |-> miss_q[0] >= 16'(PERSIST)); // R2
    AST_CONN_SET_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn_defect) |-> run_q[1] >= 16'(PERSIST)); // R3
    AST_CONN_CLR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conn_defect) |-> miss_q[1] >= 16'(PERSIST)); // R3
    AST_PAY_SET_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pay_defect) |-> run_q[2] >= 16'(PERSIST)); // R4
    AST_PAY_CLR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pay_defect) |-> miss_q[2] >= 16'(PERSIST)); // R4
    AST_CLEAN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && clean) |=> !($rose(srv_defect) || $rose(conn_defect) || $rose(pay_defect))); // R5
    AST_ONE_CLASS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({$rose(srv_defect), $rose(conn_defect), $rose(pay_defect)})); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable({srv_defect, conn_defect, pay_defect})); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !(srv_defect || conn_defect || pay_defect)); // R9
endmodule

bind rdi_defect_detector rdi_defect_checker #(.PERSIST(PERSIST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_vld   (frame_vld),
    .path_code   (path_code),
    .srv_defect  (srv_defect),
    .conn_defect (conn_defect),
    .pay_defect  (pay_defect)
);

// File: tb/sim_rdi_defect_detector.sv
module sim_rdi_defect_detector;
    localparam int P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic [2:0] path_code = 3'b000;
    logic       srv_defect, conn_defect, pay_defect;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_flag [3];
    int exp_run  [3];
    bit done = 1'b0;

    always #2 clk = ~clk;

    rdi_defect_detector #(.PERSIST(P)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .path_code(path_code),
        .srv_defect(srv_defect), .conn_defect(conn_defect), .pay_defect(pay_defect)
    );

    // Class membership taken from the requirement text (R1, R3, R4).
    function automatic bit in_class(input logic [2:0] c, input int k);
        case (k)
            0:       return (c == 3'b101) || (c == 3'b100) || (c == 3'b111);
            1:       return c == 3'b110;
            default: return c == 3'b010;
        endcase
    endfunction

    function automatic int got_flag(input int k);
        case (k)
            0:       return int'(srv_defect);
            1:       return int'(conn_defect);
            default: return int'(pay_defect);
        endcase
    endfunction

    task automatic check(input int k, input string req);
        n_chk++;
        if (got_flag(k) != exp_flag[k]) begin
            n_fail++;
            $display("FAIL %s class %0d: got %0d expected %0d at %0t",
                     req, k, got_flag(k), exp_flag[k], $time);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare just after it.
    task automatic step(input bit v, input logic [2:0] c, input string req);
        @(negedge clk);
        frame_vld = v;
        path_code = c;
        @(posedge clk);
        if (v) begin
            for (int k = 0; k < 3; k++) begin
                if (int'(in_class(c, k)) != exp_flag[k]) begin
                    exp_run[k]++;
                    if (exp_run[k] == P) begin
                        exp_flag[k] = 1 - exp_flag[k];
                        exp_run[k]  = 0;
                    end
                end else begin
                    exp_run[k] = 0;
                end
            end
        end
        #1;
        for (int k = 0; k < 3; k++) check(k, req);
    endtask

    task automatic frames(input int n, input logic [2:0] c, input string req);
        for (int i = 0; i < n; i++) step(1'b1, c, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frame_vld = 1'b0;
        for (int k = 0; k < 3; k++) begin exp_flag[k] = 0; exp_run[k] = 0; end
        @(negedge clk);
        for (int k = 0; k < 3; k++) check(k, "R9");
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) begin exp_flag[k] = 0; exp_run[k] = 0; end
        do_reset();
        step(1'b0, 3'b101, "R9");

        // R1: nine mixed server codes leave it clear, the tenth sets it
        frames(3, 3'b101, "R1"); frames(3, 3'b100, "R1"); frames(3, 3'b111, "R1");
        frames(1, 3'b101, "R1");
        // R8: idle cycles with server-like and other codes change nothing
        for (int i = 0; i < 5; i++) step(1'b0, 3'(i), "R8");
        // R2: clean codes clear it after ten
        frames(9, 3'b001, "R2"); frames(1, 3'b000, "R2");

        // R7: broken run does not set
        frames(9, 3'b010, "R7"); frames(1, 3'b011, "R7"); frames(9, 3'b010, "R7");
        frames(1, 3'b010, "R4");
        // R6: 110 clears payload, sets connectivity, never server
        frames(P, 3'b110, "R6");
        frames(P, 3'b011, "R3");

        // R8: gaps between matching frames do not break a run
        for (int i = 0; i < P; i++) begin
            step(1'b1, 3'b100, "R8");
            step(1'b0, 3'b000, "R8");
        end
        // R5: clean codes then clear
        frames(4, 3'b000, "R5"); frames(3, 3'b001, "R5"); frames(3, 3'b011, "R5");

        // Random runs of one code with idle gaps
        for (int r = 0; r < 400; r++) begin
            logic [2:0] c;
            int len;
            c   = 3'($urandom_range(0, 7));
            len = $urandom_range(1, 14);
            for (int i = 0; i < len; i++) begin
                if ($urandom_range(0, 3) == 0) step(1'b0, 3'($urandom), "R8");
                step(1'b1, c, "R1 R2 R3 R4 R5 R6 R7");
            end
        end

        do_reset();
        step(1'b0, 3'b000, "R9");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: run did not complete, got hang expected finish");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule